// File: doc/BRIEF.md
# MSI Write-Back Snoop Controller

This block is the coherence controller of one private write-back cache on a shared bus where each transaction completes in one cycle. Every line is invalid, shared (clean) or modified (dirty). The controller holds the state, tag and one data word per line of a direct-mapped cache. It serves processor loads and stores. When the protocol requires it, it starts a bus read, a bus read-exclusive or a write-back. It also watches the transactions of the other caches and changes its own lines to match. When it owns a dirty copy that another cache asks for, it puts that copy on the bus.

The processor side is a valid/ready channel. The processor raises `cpu_valid` and holds the address, direction and write data unchanged until `cpu_ready` is high. Read data is valid in the `cpu_ready` cycle. The own-bus channel is also valid/ready. `bus_req` is the valid, and the external arbiter's `bus_gnt` is the ready. A transaction takes place in the cycle where both are high, and `bus_rdata` is captured at the end of that cycle. While a request waits for its grant, its command and address do not change. A snooped transaction is shown on `snp_valid`, `snp_cmd` and `snp_addr`. The reply `snp_flush` and `snp_data` is combinational in the same cycle. The arbiter never grants this cache in a cycle that carries a snooped transaction.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpu_ready`, `bus_req` and `snp_flush` are low, and no snooped address causes a flush.
- R2: A read that misses starts a bus read (command code 1) for the requested address. The line then becomes shared, even when no other cache holds a copy, and the read completes in the next cycle with the fetched word.
- R3: A write to a line that is invalid or holds another tag starts a read-exclusive (command code 2) for the requested address. The line becomes modified and the write completes in the next cycle.
- R4: A write that hits a shared line still starts a read-exclusive for that address, and the line is upgraded to modified.
- R5: A read that hits a shared or modified line, and a write that hits a modified line, raise `cpu_ready` with no bus transaction.
- R6: A snooped read-exclusive that hits a line invalidates it. If the line was modified, `snp_flush` is high in that cycle and `snp_data` carries the dirty word.
- R7: A snooped bus read that hits a modified line flushes the word and demotes the line to shared. A snooped bus read of a shared line changes nothing. Snooped write-backs (code 3) and snoops whose tag misses have no effect.
- R8: A miss whose victim line is shared replaces it with no write-back. A modified victim is first written back (command code 3) with its own address and data, and only then is the new line fetched.
- R9: In a cycle with `snp_valid` high, the snoop is handled first. Neither `bus_req` nor `cpu_ready` is raised, and the pending processor request is evaluated again against the updated state in a later cycle.
- R10: The processor holds its request until `cpu_ready`, and read data is valid in that cycle. A bus transaction occurs exactly in a cycle with `bus_req` and `bus_gnt` both high, and `bus_cmd` is never 0 while `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor request completes this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Own bus transaction valid |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Address of the own transaction |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant; the transaction happens this cycle |
| bus_rdata | input | DATA_W | Fill data for a read or read-exclusive |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the dirty word |
| snp_data | output | DATA_W | Supplied word |

## Verification
The checker tests several properties on every cycle. A snoop cycle never carries an own request or a completion. A flush only answers a bus read or read-exclusive. A second read-exclusive or bus read to the same address right after a flush finds nothing left to supply. A fill is followed by completion, and a write-back is followed by a fetch. Other behaviour can only be shown by the bench's scenarios: which transaction a given state starts, that data comes back correctly through fills and flushes, that a shared victim is dropped silently, and that a store hit is turned into a read-exclusive when a snoop takes its line in the same cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_READX = 2'd2,
    BC_WB    = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx_a,
  output line_st_t          st_a,
  output logic [TAG_W-1:0]  tag_a,
  output logic [DATA_W-1:0] dat_a,
  input  logic [IDX_W-1:0]  idx_b,
  output line_st_t          st_b,
  output logic [TAG_W-1:0]  tag_b,
  output logic [DATA_W-1:0] dat_b,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              we_st,
  input  line_st_t          wr_st,
  input  logic              we_tag,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              we_dat,
  input  logic [DATA_W-1:0] wr_dat
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else if (we_st) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (we_tag) tag_q[wr_idx] <= wr_tag;
    if (we_dat) dat_q[wr_idx] <= wr_dat;
  end

  assign st_a  = st_q[idx_a];
  assign tag_a = tag_q[idx_a];
  assign dat_a = dat_q[idx_a];
  assign st_b  = st_q[idx_b];
  assign tag_b = tag_q[idx_b];
  assign dat_b = dat_q[idx_b];
endmodule

// File: rtl/msi_snoop_side.sv
module msi_snoop_side
  import msi_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic             snp_valid,
  input  bus_cmd_t         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             flush,
  output logic             upd,
  output line_st_t         new_st
);
  logic hit;
  assign hit = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);

  always_comb begin
    flush  = 1'b0;
    upd    = 1'b0;
    new_st = line_st;
    if (hit) begin
      unique case (snp_cmd)
        BC_READ: if (line_st == LN_MOD) begin
          flush  = 1'b1;
          upd    = 1'b1;
          new_st = LN_SHR;
        end
        BC_READX: begin
          flush  = (line_st == LN_MOD);
          upd    = 1'b1;
          new_st = LN_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_proc_side.sv
module msi_proc_side
  import msi_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic             snp_valid,
  input  logic             bus_gnt,
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             cpu_ready,
  output logic             bus_req,
  output bus_cmd_t         bus_cmd,
  output logic             victim_sel,
  output logic             upd_st,
  output line_st_t         new_st,
  output logic             upd_tag,
  output logic             upd_dat,
  output logic             dat_from_cpu
);
  logic tag_eq, present;
  assign tag_eq  = (line_tag == cpu_tag);
  assign present = (line_st != LN_INV) && tag_eq;

  always_comb begin
    cpu_ready    = 1'b0;
    bus_req      = 1'b0;
    bus_cmd      = BC_NONE;
    victim_sel   = 1'b0;
    upd_st       = 1'b0;
    new_st       = line_st;
    upd_tag      = 1'b0;
    upd_dat      = 1'b0;
    dat_from_cpu = 1'b0;
    if (cpu_valid && !snp_valid) begin
      if (present && (!cpu_write || line_st == LN_MOD)) begin
        cpu_ready    = 1'b1;
        upd_dat      = cpu_write;
        dat_from_cpu = 1'b1;
      end else if (line_st == LN_MOD && !tag_eq) begin
        bus_req    = 1'b1;
        bus_cmd    = BC_WB;
        victim_sel = 1'b1;
        upd_st     = bus_gnt;
        new_st     = LN_INV;
      end else if (cpu_write) begin
        bus_req = 1'b1;
        bus_cmd = BC_READX;
        upd_st  = bus_gnt;
        new_st  = LN_MOD;
        upd_tag = bus_gnt;
        upd_dat = bus_gnt;
      end else begin
        bus_req = 1'b1;
        bus_cmd = BC_READ;
        upd_st  = bus_gnt;
        new_st  = LN_SHR;
        upd_tag = bus_gnt;
        upd_dat = bus_gnt;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  line_st_t          st_a, st_b;
  logic [TAG_W-1:0]  tag_a, tag_b;
  logic [DATA_W-1:0] dat_a, dat_b;

  logic     s_upd;
  line_st_t s_new;
  logic     p_upd_st, p_upd_tag, p_upd_dat, p_from_cpu, p_victim;
  line_st_t p_new;
  bus_cmd_t p_cmd;

  msi_snoop_side #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bus_cmd_t'(snp_cmd)),
    .snp_tag   (s_tag),
    .line_st   (st_b),
    .line_tag  (tag_b),
    .flush     (snp_flush),
    .upd       (s_upd),
    .new_st    (s_new)
  );

  msi_proc_side #(.TAG_W(TAG_W)) u_proc (
    .cpu_valid    (cpu_valid),
    .cpu_write    (cpu_write),
    .cpu_tag      (c_tag),
    .snp_valid    (snp_valid),
    .bus_gnt      (bus_gnt),
    .line_st      (st_a),
    .line_tag     (tag_a),
    .cpu_ready    (cpu_ready),
    .bus_req      (bus_req),
    .bus_cmd      (p_cmd),
    .victim_sel   (p_victim),
    .upd_st       (p_upd_st),
    .new_st       (p_new),
    .upd_tag      (p_upd_tag),
    .upd_dat      (p_upd_dat),
    .dat_from_cpu (p_from_cpu)
  );

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_a  (c_idx),
    .st_a   (st_a),
    .tag_a  (tag_a),
    .dat_a  (dat_a),
    .idx_b  (s_idx),
    .st_b   (st_b),
    .tag_b  (tag_b),
    .dat_b  (dat_b),
    .wr_idx (snp_valid ? s_idx : c_idx),
    .we_st  (s_upd | p_upd_st),
    .wr_st  (snp_valid ? s_new : p_new),
    .we_tag (p_upd_tag),
    .wr_tag (c_tag),
    .we_dat (p_upd_dat),
    .wr_dat (p_from_cpu ? cpu_wdata : bus_rdata)
  );

  assign bus_cmd   = p_cmd;
  assign bus_addr  = p_victim ? {tag_a, c_idx} : cpu_addr;
  assign bus_wdata = dat_a;
  assign cpu_rdata = dat_a;
  assign snp_data  = dat_b;
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_write,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_gnt,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_flush,
  input logic [DATA_W-1:0] snp_data
);
  assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req && !cpu_ready));

  assert_req_has_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_cmd != 2'd0));

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

  assert_readx_invalidates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_valid && snp_cmd == 2'd2) && snp_valid && snp_addr == $past(snp_addr))
      |-> !snp_flush);

  assert_read_demotes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_flush && snp_cmd == 2'd1) && snp_valid && snp_cmd == 2'd1
     && snp_addr == $past(snp_addr)) |-> !snp_flush);

  assert_fill_then_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req && bus_gnt && bus_cmd != 2'd3) && $past(cpu_valid) && cpu_valid
     && $stable(cpu_addr) && $stable(cpu_write) && !snp_valid) |-> cpu_ready);

  assert_wb_then_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req && bus_gnt && bus_cmd == 2'd3) && $past(cpu_valid) && cpu_valid
     && $stable(cpu_addr) && $stable(cpu_write) && !snp_valid)
      |-> (bus_req && bus_cmd != 2'd3));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;
  localparam int AW = 16;
  localparam int DW = 32;

  typedef struct {
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } bus_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, bus_req, bus_gnt, snp_flush;
  logic [DW-1:0] cpu_rdata, bus_wdata, bus_rdata, snp_data;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;

  logic [DW-1:0] mem [256];
  bus_item_t bus_q[$];
  logic [DW-1:0] rd_q[$];
  string rd_req[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign bus_gnt   = bus_req;
  assign bus_rdata = mem[bus_addr[7:0]];

  msi_snoop_ctrl i_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_data(snp_data)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as the design produces results
  always @(negedge clk) begin
    #5;
    if (rst_n && !finished) begin
      if (bus_req && bus_gnt) begin
        if (bus_q.size() == 0) begin
          chk("R5 unexpected bus transaction", {30'd0, bus_cmd}, 32'd0);
        end else begin
          bus_item_t it;
          it = bus_q.pop_front();
          chk({it.req, " bus_cmd"}, {30'd0, bus_cmd}, {30'd0, it.cmd});
          chk({it.req, " bus_addr"}, {16'd0, bus_addr}, {16'd0, it.addr});
          if (it.cmd == 2'd3) begin
            chk({it.req, " bus_wdata"}, bus_wdata, it.data);
            mem[bus_addr[7:0]] = bus_wdata;
          end
        end
      end
      if (snp_flush) mem[snp_addr[7:0]] = snp_data;
      if (cpu_valid && cpu_ready && !cpu_write) begin
        if (rd_q.size() == 0) chk("R10 unexpected read completion", 32'd1, 32'd0);
        else chk({rd_req.pop_front(), " cpu_rdata"}, cpu_rdata, rd_q.pop_front());
      end
    end
  end

  task automatic exp_bus(input logic [1:0] c, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string req);
    bus_item_t it;
    it.cmd = c; it.addr = a; it.data = d; it.req = req;
    bus_q.push_back(it);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    forever begin
      #5;
      if (cpu_ready) break;
      n++;
      if (n > 20) begin
        chk({req, " no completion"}, 32'd0, 32'd1);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_valid = 1'b0;
    chk({req, " bus traffic as expected"}, bus_q.size(), 32'd0);
  endtask

  task automatic cpu_op(input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string req);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = a; cpu_wdata = d;
    wait_done(req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    rd_q.push_back(exp);
    rd_req.push_back(req);
    cpu_op(1'b0, a, '0, req);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic fl,
                       input logic [DW-1:0] d, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #5;
    chk({req, " snp_flush"}, {31'd0, snp_flush}, {31'd0, fl});
    if (fl) chk({req, " snp_data"}, snp_data, d);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 cpu_ready after reset", {31'd0, cpu_ready}, 32'd0);
    chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
    chk("R1 snp_flush after reset", {31'd0, snp_flush}, 32'd0);
    snoop(2'd2, 16'h0010, 1'b0, '0, "R1 readx snoop on empty cache");
    snoop(2'd1, 16'h0040, 1'b0, '0, "R1 read snoop on empty cache");

    exp_bus(2'd1, 16'h0010, '0, "R2 read miss");
    rd(16'h0010, 32'hA000_0010, "R2 read miss");
    rd(16'h0010, 32'hA000_0010, "R5 read hit shared");
    snoop(2'd1, 16'h0010, 1'b0, '0, "R7 read snoop of shared");
    rd(16'h0010, 32'hA000_0010, "R7 shared kept after read snoop");
    snoop(2'd2, 16'h0010, 1'b0, '0, "R6 readx snoop of shared");
    exp_bus(2'd1, 16'h0010, '0, "R6 refetch after invalidate");
    rd(16'h0010, 32'hA000_0010, "R6 refetch after invalidate");

    exp_bus(2'd2, 16'h0010, '0, "R4 upgrade");
    cpu_op(1'b1, 16'h0010, 32'h1111_1111, "R4 write hit shared");
    rd(16'h0010, 32'h1111_1111, "R5 read hit modified");
    cpu_op(1'b1, 16'h0010, 32'h2222_2222, "R5 write hit modified");
    snoop(2'd3, 16'h0010, 1'b0, '0, "R7 writeback snoop ignored");
    snoop(2'd1, 16'h0018, 1'b0, '0, "R7 snoop tag miss ignored");
    snoop(2'd1, 16'h0010, 1'b1, 32'h2222_2222, "R7 read snoop flushes modified");
    exp_bus(2'd2, 16'h0010, '0, "R7 demoted line needs upgrade");
    cpu_op(1'b1, 16'h0010, 32'h3333_3333, "R7 demoted line needs upgrade");
    snoop(2'd2, 16'h0010, 1'b1, 32'h3333_3333, "R6 readx snoop flushes modified");
    exp_bus(2'd1, 16'h0010, '0, "R6 refetch flushed word");
    rd(16'h0010, 32'h3333_3333, "R6 refetch flushed word");

    exp_bus(2'd2, 16'h0021, '0, "R3 write miss invalid");
    cpu_op(1'b1, 16'h0021, 32'h4444_4444, "R3 write miss invalid");
    exp_bus(2'd3, 16'h0021, 32'h4444_4444, "R8 dirty victim writeback");
    exp_bus(2'd2, 16'h0029, '0, "R3 write miss after victim");
    cpu_op(1'b1, 16'h0029, 32'h5555_5555, "R8 R3 write miss dirty victim");
    exp_bus(2'd3, 16'h0029, 32'h5555_5555, "R8 dirty victim writeback");
    exp_bus(2'd1, 16'h0021, '0, "R8 fetch after writeback");
    rd(16'h0021, 32'h4444_4444, "R8 read miss dirty victim");

    exp_bus(2'd1, 16'h0018, '0, "R8 clean victim silent");
    rd(16'h0018, 32'hA000_0018, "R8 clean victim silent");
    exp_bus(2'd1, 16'h0010, '0, "R8 clean victim silent back");
    rd(16'h0010, 32'h3333_3333, "R8 clean victim silent back");

    exp_bus(2'd2, 16'h0032, '0, "R3 write miss");
    cpu_op(1'b1, 16'h0032, 32'h6666_6666, "R3 write miss");
    // store hit on a modified line meets a read-exclusive snoop in the same cycle
    exp_bus(2'd2, 16'h0032, '0, "R9 re-evaluated after snoop");
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 16'h0032; cpu_wdata = 32'h7777_7777;
    snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 16'h0032;
    #5;
    chk("R9 snoop flush wins", {31'd0, snp_flush}, 32'd1);
    chk("R9 snoop data", snp_data, 32'h6666_6666);
    chk("R9 no cpu_ready in snoop cycle", {31'd0, cpu_ready}, 32'd0);
    chk("R9 no bus_req in snoop cycle", {31'd0, bus_req}, 32'd0);
    @(negedge clk);
    snp_valid = 1'b0;
    wait_done("R9 re-evaluated after snoop");
    rd(16'h0032, 32'h7777_7777, "R9 R5 store landed");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule